// File: doc/BRIEF.md
# Selectable Link Event Statistics Counters

This block keeps a bank of event counters for a multi-lane serial link controller. Event detectors elsewhere in the controller raise one-cycle pulses. Some events are tracked per lane, on one vector per lane. The others are tracked for the whole link, on one shared vector. Software never sees the whole bank at once. It programs a selector made of group, event and lane fields into a single control register. It then starts or stops the chosen counter with a small command code in the same register, checks whether that counter is running, and reads its value from a data register.

Starting a counter that is stopped clears it, so software collects a fresh measurement window by stopping and restarting. Counters saturate at their maximum value instead of wrapping. Selector combinations that name no counter are inert. The register port is a plain single-cycle write strobe with an asynchronous read mux, so there is no back-pressure at the block's edge. The event inputs have no handshake either: a pulse that is high at a clock edge is one occurrence.

Top module: `lnkstat_bank`

## Requirements
- R1: After reset every counter is stopped with a count of zero, all selector fields are zero (lane 0), and the control register reads 0.
- R2: The control register is at offset 0x8 and the data register at offset 0xC. Reads of any other offset return 0. Writes to any offset other than 0x8, including 0xC, change nothing.
- R3: Control register layout: bits 27:24 group, 23:16 event, 11:8 lane, bit 7 run status of the selected counter, bits 4:2 command. The group, event and lane fields read back exactly as last written. The command field and all other bits read as 0.
- R4: A command of 3 in a control write starts only the counter named by the selectors in that same write. A command of 1 stops only that counter. Any other command value leaves every counter unchanged.
- R5: Starting a stopped counter sets its count to 0. Starting a counter that is already running keeps its count.
- R6: A running counter adds one on each clock edge at which its event input is high, and the new value can be read after that edge. A stopped counter holds its value, which stays readable. An event at the same edge as a stop command is still counted.
- R7: A count that has reached all ones stays at all ones while further events arrive.
- R8: Supported selectors: group 0 events 0–10, group 1 events 5–10 and 12–13, group 2 events 0–7, group 3 events 0–5, group 4 events 0–1. Lane-specific selectors also need a lane below NUM_LANES. Any other selector reads status 0 and count 0, and commands to it change no counter.
- R9: Groups 0 and 4 are lane-specific. Lane L uses bits L*13+0..L*13+10 of lane_evt for group 0 events 0–10, and bits L*13+11..L*13+12 for group 4 events 0–1. Groups 1–3 are link-wide and ignore the lane field. Their events use link_evt bits 0–7 for group 1 events 5,6,7,8,9,10,12,13, bits 8–15 for group 2 events 0–7, and bits 16–21 for group 3 events 0–5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lane_evt | input | NUM_LANES*13 | Per-lane event pulses, 13 bits per lane |
| link_evt | input | 22 | Link-wide event pulses |

## Verification
The hardest state to reach is saturation, because a 32-bit count needs billions of events. The bench therefore builds the bank with an 8-bit count width. It starts one link-wide counter and holds its event high for several hundred cycles, then keeps it high to confirm the value stays pinned. A second hard case is one command landing on exactly one of 74 counters while events keep arriving on many others. For this, random control writes with random selectors (many out of range) and random command codes are mixed with dense random event vectors, and a bench-side model of every counter is compared with both registers after each cycle.

// File: rtl/lnkstat_pkg.sv
package lnkstat_pkg;
  localparam int LANE_EVTS = 13;   // group 0 (11) + group 4 (2) per lane
  localparam int LINK_EVTS = 22;   // group 1 (8) + group 2 (8) + group 3 (6)
  localparam int G0_EVTS   = 11;
  localparam int G4_EVTS   = 2;
  localparam int G1_FIRST  = 5;
  localparam int G1_LOW_LAST = 10;
  localparam int G1_HI_FIRST = 12;
  localparam int G1_HI_LAST  = 13;
  localparam int G1_SLOTS  = 8;
  localparam int G2_EVTS   = 8;
  localparam int G3_EVTS   = 6;

  localparam logic [2:0] CMD_START = 3'd3;
  localparam logic [2:0] CMD_STOP  = 3'd1;

  localparam int CTRL_OFS = 8;
  localparam int DATA_OFS = 12;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;
endpackage

// File: rtl/lnkstat_sel_decode.sv
module lnkstat_sel_decode
  import lnkstat_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = 7
) (
  input  sel_t             sel,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int LINK_BASE = NUM_LANES * LANE_EVTS;

  always_comb begin
    int lane_i;
    int evt_i;
    logic lane_ok;
    lane_i  = int'(sel.lane);
    evt_i   = int'(sel.evt);
    lane_ok = lane_i < NUM_LANES;
    hit     = 1'b0;
    idx     = '0;
    case (sel.grp)
      4'd0: if (evt_i < G0_EVTS && lane_ok) begin
        hit = 1'b1;
        idx = IDX_W'(lane_i * LANE_EVTS + evt_i);
      end
      4'd4: if (evt_i < G4_EVTS && lane_ok) begin
        hit = 1'b1;
        idx = IDX_W'(lane_i * LANE_EVTS + G0_EVTS + evt_i);
      end
      4'd1: begin
        if (evt_i >= G1_FIRST && evt_i <= G1_LOW_LAST) begin
          hit = 1'b1;
          idx = IDX_W'(LINK_BASE + evt_i - G1_FIRST);
        end else if (evt_i >= G1_HI_FIRST && evt_i <= G1_HI_LAST) begin
          hit = 1'b1;
          idx = IDX_W'(LINK_BASE + evt_i - G1_FIRST - 1);
        end
      end
      4'd2: if (evt_i < G2_EVTS) begin
        hit = 1'b1;
        idx = IDX_W'(LINK_BASE + G1_SLOTS + evt_i);
      end
      4'd3: if (evt_i < G3_EVTS) begin
        hit = 1'b1;
        idx = IDX_W'(LINK_BASE + G1_SLOTS + G2_EVTS + evt_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lnkstat_counter.sv
module lnkstat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             cmd_on,
  input  logic             cmd_off,
  output logic             en,
  output logic [CNT_W-1:0] count
);
  logic sat;
  assign sat = &count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      count <= '0;
    end else begin
      if (cmd_on && !en)
        count <= '0;
      else if (en && evt && !sat)
        count <= count + 1'b1;
      if (cmd_on)
        en <= 1'b1;
      else if (cmd_off)
        en <= 1'b0;
    end
  end

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && !en) |=> (en && count == '0));

  assert_keep_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && en && !evt) |=> (en && $stable(count)));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cmd_on) |=> $stable(count));

  assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt && !sat) |=> (count == $past(count) + CNT_W'(1)));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !(cmd_on && !en)) |=> (&count));
endmodule

// File: rtl/lnkstat_bank.sv
module lnkstat_bank
  import lnkstat_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [31:0]                    reg_wdata,
  output logic [31:0]                    reg_rdata,
  input  logic [NUM_LANES*LANE_EVTS-1:0] lane_evt,
  input  logic [LINK_EVTS-1:0]           link_evt
);
  localparam int NUM_CNT = NUM_LANES * LANE_EVTS + LINK_EVTS;
  localparam int IDX_W   = $clog2(NUM_CNT);

  sel_t             sel_q;
  sel_t             wsel;
  logic             wr_ctrl;
  logic [2:0]       cmd;
  logic             w_hit, r_hit;
  logic [IDX_W-1:0] w_idx, r_idx;
  logic [NUM_CNT-1:0] evt_all, on_vec, off_vec, en_vec;
  logic [CNT_W-1:0] cnt_arr [NUM_CNT];
  logic             sel_status;
  logic [CNT_W-1:0] sel_count;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
  assign wsel    = '{grp: reg_wdata[27:24], evt: reg_wdata[23:16], lane: reg_wdata[11:8]};
  assign cmd     = reg_wdata[4:2];
  assign evt_all = {link_evt, lane_evt};

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= '0;
    else if (wr_ctrl)
      sel_q <= wsel;
  end

  lnkstat_sel_decode #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_wdec (
    .sel(wsel), .hit(w_hit), .idx(w_idx));

  lnkstat_sel_decode #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_rdec (
    .sel(sel_q), .hit(r_hit), .idx(r_idx));

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      on_vec[i]  = wr_ctrl && w_hit && (w_idx == IDX_W'(i)) && (cmd == CMD_START);
      off_vec[i] = wr_ctrl && w_hit && (w_idx == IDX_W'(i)) && (cmd == CMD_STOP);
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    lnkstat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[i]),
      .cmd_on (on_vec[i]),
      .cmd_off(off_vec[i]),
      .en     (en_vec[i]),
      .count  (cnt_arr[i])
    );
  end

  always_comb begin
    sel_status = 1'b0;
    sel_count  = '0;
    if (r_hit && int'(r_idx) < NUM_CNT) begin
      sel_status = en_vec[r_idx];
      sel_count  = cnt_arr[r_idx];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_OFS)) begin
      reg_rdata[27:24] = sel_q.grp;
      reg_rdata[23:16] = sel_q.evt;
      reg_rdata[11:8]  = sel_q.lane;
      reg_rdata[7]     = sel_status;
    end else if (reg_addr == ADDR_W'(DATA_OFS)) begin
      reg_rdata[CNT_W-1:0] = sel_count;
    end
  end

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(on_vec | off_vec));

  assert_bad_sel_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_hit) |=> (en_vec == $past(en_vec)));

  assert_other_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl) |=> ($stable(sel_q) && en_vec == $past(en_vec)));
endmodule

// File: tb/lnkstat_bank_bench.sv
module lnkstat_bank_bench;
  localparam int NL = 4;
  localparam int CW = 8;
  localparam int NC = NL * 13 + 22;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL*13-1:0] lane_evt = '0;
  logic [21:0] link_evt = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_cnt [NC];
  bit m_en  [NC];
  logic [3:0] m_grp = '0, m_lane = '0;
  logic [7:0] m_evt = '0;

  always #10 clk = ~clk;

  lnkstat_bank #(.NUM_LANES(NL), .CNT_W(CW), .ADDR_W(4)) u_lnkstat_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lane_evt(lane_evt), .link_evt(link_evt));

  function automatic int bidx(logic [3:0] g, logic [7:0] e, logic [3:0] l);
    int ev = int'(e);
    int ln = int'(l);
    if (g == 0 && ev <= 10 && ln < NL) return ln * 13 + ev;
    if (g == 4 && ev <= 1 && ln < NL) return ln * 13 + 11 + ev;
    if (g == 1 && ev >= 5 && ev <= 10) return NL * 13 + ev - 5;
    if (g == 1 && (ev == 12 || ev == 13)) return NL * 13 + ev - 6;
    if (g == 2 && ev <= 7) return NL * 13 + 8 + ev;
    if (g == 3 && ev <= 5) return NL * 13 + 16 + ev;
    return -1;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    int k = bidx(m_grp, m_evt, m_lane);
    logic st = (k >= 0) ? m_en[k] : 1'b0;
    return {4'h0, m_grp, m_evt, 4'h0, m_lane, st, 7'h0};
  endfunction

  function automatic logic [31:0] exp_data();
    int k = bidx(m_grp, m_evt, m_lane);
    return (k >= 0) ? 32'(m_cnt[k]) : 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock edge; model follows the inputs currently driven
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_en[i] = 1'b0; end
      m_grp = '0; m_evt = '0; m_lane = '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        bit ev = (i < NL * 13) ? lane_evt[i] : link_evt[i - NL * 13];
        if (m_en[i] && ev && m_cnt[i] < MAXC) m_cnt[i]++;
      end
      if (reg_wr && reg_addr == 4'h8) begin
        int k;
        m_grp = reg_wdata[27:24]; m_evt = reg_wdata[23:16]; m_lane = reg_wdata[11:8];
        k = bidx(m_grp, m_evt, m_lane);
        if (k >= 0 && reg_wdata[4:2] == 3'd3) begin
          if (!m_en[k]) m_cnt[k] = 0;
          m_en[k] = 1'b1;
        end else if (k >= 0 && reg_wdata[4:2] == 3'd1) begin
          m_en[k] = 1'b0;
        end
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_ctrl(int g, int e, int l, int c);
    reg_wr = 1'b1; reg_addr = 4'h8;
    reg_wdata = {4'h0, 4'(g), 8'(e), 4'h0, 4'(l), 3'h0, 3'(c), 2'h0};
    step();
  endtask

  task automatic check_regs(string tag);
    reg_addr = 4'h8; #1; check({tag, " ctrl"}, reg_rdata, exp_ctrl());
    reg_addr = 4'hC; #1; check({tag, " data"}, reg_rdata, exp_data());
  endtask

  task automatic pulse_link(int bitn, int n);
    for (int i = 0; i < n; i++) begin
      link_evt = '0; link_evt[bitn] = 1'b1; step();
    end
    link_evt = '0;
  endtask

  task automatic pulse_lane(int bitn, int n);
    for (int i = 0; i < n; i++) begin
      lane_evt = '0; lane_evt[bitn] = 1'b1; step();
    end
    lane_evt = '0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check_regs("R1 reset");
    reg_addr = 4'h8; #1; check("R1 ctrl zero", reg_rdata, 32'h0);

    // R9 link-wide group 1 event 12 ignores lane
    wr_ctrl(1, 12, 0, 3);
    pulse_link(6, 3);
    wr_ctrl(1, 12, 3, 0);
    reg_addr = 4'hC; #1; check("R9 link-wide lane ignored", reg_rdata, 32'd3);
    reg_addr = 4'h8; #1; check("R3 readback cmd zero", reg_rdata, 32'h010C_0380);

    // R9 lane-specific: lane 1 group 0 event 2 counts, lane 0 not
    wr_ctrl(0, 2, 1, 3);
    pulse_lane(1 * 13 + 2, 2);
    pulse_lane(0 * 13 + 2, 4);
    check_regs("R9 lane1");
    reg_addr = 4'hC; #1; check("R9 lane1 count", reg_rdata, 32'd2);
    wr_ctrl(0, 2, 0, 0);
    reg_addr = 4'hC; #1; check("R9 lane0 separate", reg_rdata, 32'd0);
    // group 4 event 1 on lane 2
    wr_ctrl(4, 1, 2, 3);
    pulse_lane(2 * 13 + 12, 5);
    check_regs("R9 group4");

    // R5 restart semantics
    wr_ctrl(2, 3, 0, 3);
    pulse_link(11, 4);
    wr_ctrl(2, 3, 0, 3);
    reg_addr = 4'hC; #1; check("R5 start while running keeps", reg_rdata, 32'd4);
    wr_ctrl(2, 3, 0, 1);
    pulse_link(11, 2);
    reg_addr = 4'hC; #1; check("R6 stopped holds", reg_rdata, 32'd4);
    reg_addr = 4'h8; #1; check("R4 stop status", reg_rdata[7], 1'b0);
    wr_ctrl(2, 3, 0, 3);
    reg_addr = 4'hC; #1; check("R5 restart zero", reg_rdata, 32'd0);
    // R6 event on stop edge counts
    link_evt[11] = 1'b1;
    wr_ctrl(2, 3, 0, 1);
    link_evt = '0;
    reg_addr = 4'hC; #1; check("R6 event at stop edge", reg_rdata, 32'd1);

    // R4 other command codes inert
    wr_ctrl(3, 0, 0, 7);
    reg_addr = 4'h8; #1; check("R4 code 7 inert", reg_rdata[7], 1'b0);
    wr_ctrl(3, 0, 0, 2);
    check_regs("R4 code 2 inert");

    // R7 saturation
    wr_ctrl(3, 5, 0, 3);
    link_evt[21] = 1'b1;
    for (int i = 0; i < 300; i++) step();
    reg_addr = 4'hC; #1; check("R7 saturated", reg_rdata, 32'(MAXC));
    for (int i = 0; i < 20; i++) step();
    reg_addr = 4'hC; #1; check("R7 stays saturated", reg_rdata, 32'(MAXC));
    link_evt = '0;

    // R2 writes to other offsets, reads of other offsets
    reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = 32'h0200_000C; step();
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0300_010C; step();
    check_regs("R2 writes elsewhere inert");
    reg_addr = 4'h4; #1; check("R2 other offset reads 0", reg_rdata, 32'h0);

    // R8 unsupported selections
    wr_ctrl(1, 11, 0, 3);
    check_regs("R8 group1 event 11");
    wr_ctrl(0, 2, 4, 3);
    check_regs("R8 lane 4");
    wr_ctrl(5, 0, 0, 3);
    check_regs("R8 group 5");

    // random mix, R4 R5 R6 R8 checked against the model
    for (int it = 0; it < 1500; it++) begin
      int op = int'($urandom % 8);
      lane_evt = NL*13'({$urandom, $urandom} & {$urandom, $urandom});
      link_evt = 22'($urandom & $urandom);
      if (op < 3) begin
        int c = int'($urandom % 4);
        c = (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? int'($urandom % 8) : 3;
        wr_ctrl(int'($urandom % 6), int'($urandom % 16), int'($urandom % 6), c);
      end else if (op == 3) begin
        reg_wr = 1'b1; reg_addr = 4'($urandom); reg_wdata = $urandom;
        if (reg_addr == 4'h8) reg_addr = 4'hC;
        step();
      end else begin
        step();
      end
      lane_evt = '0; link_evt = '0;
      check_regs("R6 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule